// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This unit is the integer data-processing stage of a small RISC execute pipe. For each operation it takes a 4-bit operation code, a set-flags bit, a bit that marks the second operand as an immediate, and two 32-bit operands. The second operand arrives already shifted or expanded. The unit returns the 32-bit result and a write-enable for the destination register. It also returns the flag values that the operation would produce.

The unit keeps the four condition flags (negative, zero, carry, overflow) in its own status register. These stored flags feed the carry-in of the carry-using operations and supply any flag that an operation leaves alone. The register loads on a rising clock edge only when the operation is valid and asks for a flag update.

The sixteen operations fall into three groups. The logical group contains the bitwise and move forms. The add group adds with or without the incoming carry. The subtract group contains normal and reversed subtracts, with or without the incoming carry. Four compare and test forms produce flags only.

Top module: `dp_alu`

## Requirements
- R1: Operation codes 0000 AND (A&B), 0001 EOR (A^B), 1100 ORR (A|B), 1101 MOV (B), 1110 BIC (A&~B), 1111 MVN (~B) produce these results on `result` in the same cycle. MOV and MVN take no part of A.
- R2: Code 0100 ADD gives A+B and code 0101 ADC gives A+B+C, both modulo 2^32, where C is the stored carry flag.
- R3: Code 0010 SUB gives A-B. Code 0011 RSB gives B-A. Code 0110 SBC gives A-B-(1-C). Code 0111 RSC gives B-A-(1-C). All four wrap modulo 2^32.
- R4: `rd_we` is high exactly when `valid` is high and the code is not one of 1000 TST, 1001 TEQ, 1010 CMP or 1011 CMN. These four compute flags as AND, EOR, SUB and ADD respectively.
- R5: When flags are set, N becomes result bit 31, and Z becomes 1 exactly when the 32-bit result is zero.
- R6: For ADD, ADC and CMN with flags set, C becomes the carry out of bit 31. V becomes 1 when both addends have the same sign and the result's sign differs from it.
- R7: For SUB, RSB and CMP with flags set, C becomes 1 when the minuend is greater than or equal to the subtrahend as unsigned numbers. V becomes 1 when the operand signs differ and the result's sign differs from the minuend's.
- R8: For SBC and RSC with flags set, C becomes 1 exactly when the full subtraction minuend-subtrahend-(1-C) does not borrow. V uses the signed-overflow rule of R7.
- R9: For the logical group and TST/TEQ with flags set, V keeps its stored value. C becomes bit 31 of B when `b_is_imm` is high and B is greater than 255; otherwise C keeps its stored value.
- R10: `flags_q` is {N,Z,C,V} in bits 3..0 and resets synchronously to 0000. It loads `flags_next` on a rising edge only when both `valid` and `set_flags` are high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (see R1 to R4) |
| set_flags | input | 1 | Request a flag update for this operation |
| b_is_imm | input | 1 | Operand B came from an immediate field |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already shifted or expanded |
| result | output | 32 | Operation result, combinational |
| rd_we | output | 1 | Destination register write-enable |
| flags_next | output | 4 | Flags {N,Z,C,V} this operation would store |
| flags_q | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The properties assume the inputs are stable through each clock period and are known from the first edge after reset. Under that assumption, a sample of `result` taken after an edge can be tied to the operation that caused that edge's flag load. The stimulus drives every input on the falling edge and changes it only there, so nothing moves near the sampling edge. The directed scenarios cover the corners of the carry and overflow rules: wrap to zero, signed overflow at the most negative value, and a carry-in that turns a borrow into no borrow. They also cover the 255 immediate threshold and the cases where `valid` or `set_flags` is low.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic [1:0] {
        CLS_LOGIC = 2'd0,
        CLS_ADD   = 2'd1,
        CLS_SUB   = 2'd2
    } op_class_e;

    typedef struct packed {
        op_class_e cls;
        logic      swap;     // reversed operand order
        logic      use_cf;   // carry-in comes from the stored carry flag
        logic      writes;   // destination register is written
    } op_dec_t;

    function automatic op_dec_t decode_op(input alu_op_e op);
        op_dec_t d;
        d.cls    = CLS_LOGIC;
        d.swap   = 1'b0;
        d.use_cf = 1'b0;
        d.writes = 1'b1;
        unique case (op)
            OP_SUB: d.cls = CLS_SUB;
            OP_RSB: begin d.cls = CLS_SUB; d.swap = 1'b1; end
            OP_SBC: begin d.cls = CLS_SUB; d.use_cf = 1'b1; end
            OP_RSC: begin d.cls = CLS_SUB; d.use_cf = 1'b1; d.swap = 1'b1; end
            OP_CMP: begin d.cls = CLS_SUB; d.writes = 1'b0; end
            OP_ADD: d.cls = CLS_ADD;
            OP_ADC: begin d.cls = CLS_ADD; d.use_cf = 1'b1; end
            OP_CMN: begin d.cls = CLS_ADD; d.writes = 1'b0; end
            OP_TST, OP_TEQ: d.writes = 1'b0;
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dp_alu_arith.sv
module dp_alu_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         swap,
    input  logic         is_sub,
    input  logic         use_cf,
    input  logic         cf,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] x, y_raw, y;
    logic         cin;
    logic [W:0]   wide;

    always_comb begin
        x     = swap ? b : a;
        y_raw = swap ? a : b;
        y     = is_sub ? ~y_raw : y_raw;
        cin   = use_cf ? cf : is_sub;
        wide  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        sum   = wide[W-1:0];
        cout  = wide[W];
        ovf   = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic #(
    parameter int W = 32
) (
    input  dp_alu_pkg::alu_op_e op,
    input  logic [W-1:0]        a,
    input  logic [W-1:0]        b,
    output logic [W-1:0]        res
);
    import dp_alu_pkg::*;

    always_comb begin
        unique case (op)
            OP_AND, OP_TST: res = a & b;
            OP_EOR, OP_TEQ: res = a ^ b;
            OP_ORR:         res = a | b;
            OP_MOV:         res = b;
            OP_BIC:         res = a & ~b;
            OP_MVN:         res = ~b;
            default:        res = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu_status.sv
module dp_alu_status (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  dp_alu_pkg::nzcv_t d,
    output dp_alu_pkg::nzcv_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
    parameter int DATA_W    = 32,
    parameter int IMM_LIMIT = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [3:0]        op_code,
    input  logic              set_flags,
    input  logic              b_is_imm,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              rd_we,
    output logic [3:0]        flags_next,
    output logic [3:0]        flags_q
);
    import dp_alu_pkg::*;

    localparam logic [DATA_W-1:0] IMM_MAX = DATA_W'(IMM_LIMIT);

    alu_op_e           op;
    op_dec_t           dec;
    nzcv_t             cur, nxt;
    logic [DATA_W-1:0] arith_res, logic_res;
    logic              arith_c, arith_v;
    logic              wide_imm;

    assign op  = alu_op_e'(op_code);
    assign dec = decode_op(op);

    dp_alu_arith #(.W(DATA_W)) u_arith (
        .a      (opnd_a),
        .b      (opnd_b),
        .swap   (dec.swap),
        .is_sub (dec.cls == CLS_SUB),
        .use_cf (dec.use_cf),
        .cf     (cur.c),
        .sum    (arith_res),
        .cout   (arith_c),
        .ovf    (arith_v)
    );

    dp_alu_logic #(.W(DATA_W)) u_logic (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (logic_res)
    );

    assign wide_imm = b_is_imm && (opnd_b > IMM_MAX);

    always_comb begin
        result = (dec.cls == CLS_LOGIC) ? logic_res : arith_res;
        nxt    = cur;
        if (set_flags) begin
            nxt.n = result[DATA_W-1];
            nxt.z = (result == '0);
            if (dec.cls == CLS_LOGIC) begin
                if (wide_imm) nxt.c = opnd_b[DATA_W-1];
            end else begin
                nxt.c = arith_c;
                nxt.v = arith_v;
            end
        end
    end

    assign rd_we      = valid && dec.writes;
    assign flags_next = nxt;
    assign flags_q    = cur;

    dp_alu_status u_status (
        .clk  (clk),
        .rst  (rst),
        .load (valid && set_flags),
        .d    (nxt),
        .q    (cur)
    );
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         valid,
    input logic [3:0]   op_code,
    input logic         set_flags,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result,
    input logic         rd_we,
    input logic [3:0]   flags_q
);
    logic is_logic;
    assign is_logic = (op_code[3:2] == 2'b11) || (op_code[3:1] == 3'b000) ||
                      (op_code[3:1] == 3'b100);

    // R4
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code[3:2] == 2'b10) |-> !rd_we);

    // R4
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |-> !rd_we);

    // R1
    mov_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'hD) |-> (result == opnd_b));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid && set_flags) |=> $stable(flags_q));

    // R5
    z_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && set_flags) |=> (flags_q[2] == ($past(result) == '0)));

    // R5
    n_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && set_flags) |=> (flags_q[3] == $past(result[W-1])));

    // R9
    logic_v_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && set_flags && is_logic) |=> $stable(flags_q[0]));
endmodule

bind dp_alu dp_alu_chk #(.W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid     (valid),
    .op_code   (op_code),
    .set_flags (set_flags),
    .opnd_b    (opnd_b),
    .result    (result),
    .rd_we     (rd_we),
    .flags_q   (flags_q)
);

// File: tb/dp_alu_bench.sv
module dp_alu_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid;
    logic [3:0]  op_code;
    logic        set_flags;
    logic        b_is_imm;
    logic [31:0] opnd_a, opnd_b;
    logic [31:0] result;
    logic        rd_we;
    logic [3:0]  flags_next, flags_q;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [3:0] mflags;   // bench copy of {N,Z,C,V}

    always #(CLK_P/2) clk = ~clk;

    dp_alu u_dp_alu (
        .clk(clk), .rst(rst), .valid(valid), .op_code(op_code),
        .set_flags(set_flags), .b_is_imm(b_is_imm), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .result(result), .rd_we(rd_we),
        .flags_next(flags_next), .flags_q(flags_q)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected behaviour written from the requirements, using 64-bit arithmetic.
    task automatic model(input logic [3:0] op, input logic s, input logic imm,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic we,
                         output logic [3:0] f);
        longint ua = longint'(a), ub = longint'(b);
        longint sa = longint'($signed(a)), sb = longint'($signed(b));
        longint cin = longint'(mflags[1]);
        longint ud = 0, sd = 0;
        int cls = 0;   // 0 logic, 1 add, 2 sub
        case (op)
            4'h0, 4'h8: r = a & b;
            4'h1, 4'h9: r = a ^ b;
            4'hC: r = a | b;
            4'hD: r = b;
            4'hE: r = a & ~b;
            4'hF: r = ~b;
            4'h4, 4'hB: begin cls = 1; ud = ua + ub;       sd = sa + sb;       end
            4'h5:       begin cls = 1; ud = ua + ub + cin; sd = sa + sb + cin; end
            4'h2, 4'hA: begin cls = 2; ud = ua - ub; sd = sa - sb; end
            4'h3:       begin cls = 2; ud = ub - ua; sd = sb - sa; end
            4'h6:       begin cls = 2; ud = ua - ub - (1 - cin); sd = sa - sb - (1 - cin); end
            default:    begin cls = 2; ud = ub - ua - (1 - cin); sd = sb - sa - (1 - cin); end
        endcase
        if (cls != 0) r = ud[31:0];
        we = valid && (op[3:2] != 2'b10);
        f  = mflags;
        if (s) begin
            f[3] = r[31];
            f[2] = (r == 32'h0);
            if (cls == 1) begin
                f[1] = (ud > 64'sh0FFFF_FFFF);
                f[0] = (sd > 64'sh7FFF_FFFF) || (sd < -64'sh8000_0000);
            end else if (cls == 2) begin
                f[1] = (ud >= 0);
                f[0] = (sd > 64'sh7FFF_FFFF) || (sd < -64'sh8000_0000);
            end else if (imm && b > 32'd255) begin
                f[1] = b[31];
            end
        end
    endtask

    // Drive one operation at a falling edge, check the comb outputs,
    // then check the flag register after the next rising edge.
    task automatic run_op(input string req, input logic v, input logic [3:0] op,
                          input logic s, input logic imm,
                          input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        logic        ewe;
        logic [3:0]  ef;
        @(negedge clk);
        valid = v; op_code = op; set_flags = s; b_is_imm = imm;
        opnd_a = a; opnd_b = b;
        model(op, s, imm, a, b, er, ewe, ef);
        #1;
        chk(req, "result", result, er);
        chk(req, "rd_we", {31'h0, rd_we}, {31'h0, ewe});
        @(posedge clk);
        #1;
        if (v && s) mflags = ef;
        chk(req, "flags_q", {28'h0, flags_q}, {28'h0, mflags});
    endtask

    task automatic t_reset;
        rst = 1'b1; valid = 1'b0; op_code = 4'h0; set_flags = 1'b0;
        b_is_imm = 1'b0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(posedge clk);
        #1;
        mflags = 4'h0;
        chk("R10", "reset flags", {28'h0, flags_q}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_logic;
        run_op("R1", 1, 4'h0, 0, 0, 32'hF0F0_1234, 32'h0FF0_00FF);
        run_op("R1", 1, 4'h1, 0, 0, 32'hF0F0_1234, 32'h0FF0_00FF);
        run_op("R1", 1, 4'hC, 0, 0, 32'hF0F0_1234, 32'h0FF0_00FF);
        run_op("R1", 1, 4'hE, 0, 0, 32'hF0F0_1234, 32'h0FF0_00FF);
        run_op("R1", 1, 4'hD, 0, 0, 32'hDEAD_BEEF, 32'h1357_9BDF);
        run_op("R1", 1, 4'hF, 0, 0, 32'hDEAD_BEEF, 32'h1357_9BDF);
    endtask

    task automatic t_add;
        run_op("R6", 1, 4'h4, 1, 0, 32'h7FFF_FFFF, 32'h1);
        run_op("R6", 1, 4'h4, 1, 0, 32'hFFFF_FFFF, 32'h1);
        run_op("R2", 1, 4'h5, 1, 0, 32'h0000_0010, 32'h20);
        run_op("R2", 1, 4'h5, 1, 0, 32'h8000_0000, 32'h8000_0000);
    endtask

    task automatic t_sub;
        run_op("R7", 1, 4'h2, 1, 0, 32'd5, 32'd3);
        run_op("R7", 1, 4'h2, 1, 0, 32'd3, 32'd5);
        run_op("R7", 1, 4'h2, 1, 0, 32'h8000_0000, 32'h1);
        run_op("R3", 1, 4'h3, 1, 0, 32'd3, 32'd10);
    endtask

    task automatic t_carry_sub;
        run_op("R8", 1, 4'h2, 1, 0, 32'd1, 32'd2);
        run_op("R8", 1, 4'h6, 1, 0, 32'd10, 32'd3);
        run_op("R8", 1, 4'h6, 1, 0, 32'd4, 32'd4);
        run_op("R8", 1, 4'h7, 1, 0, 32'd3, 32'd10);
        run_op("R3", 1, 4'h7, 1, 0, 32'd7, 32'd7);
    endtask

    task automatic t_compare;
        run_op("R4", 1, 4'hA, 1, 0, 32'h55, 32'h55);
        run_op("R4", 1, 4'h8, 1, 0, 32'hF0, 32'h0F);
        run_op("R4", 1, 4'h9, 1, 0, 32'hFF, 32'h0F);
        run_op("R4", 1, 4'hB, 1, 0, 32'hFFFF_FFF0, 32'h10);
    endtask

    task automatic t_flags_nz;
        run_op("R5", 1, 4'h0, 1, 0, 32'hAAAA_AAAA, 32'h5555_5555);
        run_op("R5", 1, 4'hF, 1, 0, 32'h0, 32'h0000_0001);
    endtask

    task automatic t_logic_carry;
        run_op("R8", 1, 4'h4, 1, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        run_op("R9", 1, 4'hD, 1, 1, 32'h0, 32'h8000_0001);
        run_op("R9", 1, 4'h2, 1, 0, 32'd2, 32'd1);
        run_op("R9", 1, 4'hD, 1, 1, 32'h0, 32'h0000_0040);
        run_op("R9", 1, 4'hD, 1, 0, 32'h0, 32'h8000_0000);
        run_op("R9", 1, 4'hD, 1, 1, 32'h0, 32'h0000_0100);
        run_op("R9", 1, 4'hD, 1, 1, 32'h0, 32'h0000_00FF);
    endtask

    task automatic t_hold;
        run_op("R10", 1, 4'h4, 1, 0, 32'hFFFF_FFFF, 32'h1);
        run_op("R10", 0, 4'h2, 1, 0, 32'd1, 32'd9);
        run_op("R10", 1, 4'h2, 0, 0, 32'd1, 32'd9);
        run_op("R4", 0, 4'h4, 0, 0, 32'd1, 32'd1);
    endtask

    initial begin
        t_reset();
        t_logic();
        t_add();
        t_sub();
        t_carry_sub();
        t_compare();
        t_flags_nz();
        t_logic_carry();
        t_hold();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired before the run completed");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule